// File: doc/BRIEF.md
# Vertical Sync Pulse Generator

This block produces the vertical sync pulse for a character-based CRT timing controller. It keeps a 7-bit character row counter, a programmable sync-position register and a pulse-length counter. The horizontal section supplies two inputs. The first is a character-clock enable. The second is an end-of-scanline strobe, which goes high when the horizontal counter reaches its programmed total. The pair counts as one scanline boundary only when both are high in the same cycle.

Sync is raised when the row counter arrives at the programmed position. It then stays high for a number of scanline boundaries (16 unless reprogrammed). The same signal doubles as vertical blanking, so a second output mirrors it exactly. Writing the position register with the row currently being scanned starts a pulse at once, in mid-line. This is intended behaviour, not a fault. The row counter wraps at a programmable vertical total and flags every wrap.

Top module: `vsync_gen`

## Requirements
- R1: While rst is high and in the first cycle after it falls, vsync, vblank, frame_start and row are all 0. The position register resets to 0 and the pulse length resets to 16.
- R2: row increases by one in the cycle after each boundary, which is a cycle with char_en=1 and line_end=1. line_end with char_en=0 leaves row unchanged.
- R3: At a boundary where row equals vtotal, row becomes 0 next cycle and frame_start is 1 for exactly that one cycle. frame_start is 0 otherwise.
- R4: A line-triggered pulse starts when vsync is low and a boundary moves row onto the position value. vsync rises in the same cycle that row shows that value. Apart from R6, vsync never rises in any other cycle.
- R5: Once high, vsync stays high for exactly W further boundaries, where W is the programmed length. It falls in the cycle after the W-th boundary.
- R6: Writing the position register (wr_en=1, wr_sel=0) with a value equal to the current row, while vsync is low, raises vsync in the next cycle. The pulse then lasts W boundaries as in R5.
- R7: A position write stores wr_data and the next line-triggered pulse starts at that row. A position write whose value differs from the current row does not raise vsync.
- R8: A position write during a pulse changes neither its length nor its end, even if the written value equals the current row.
- R9: vblank equals vsync in every cycle.
- R10: A write with wr_sel=1 loads wr_data[3:0] as the pulse length, with the field value 0 meaning 16. The new length applies to pulses that start after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_en | input | 1 | Character-clock enable |
| line_end | input | 1 | Horizontal counter at its total (last character of the line) |
| vtotal | input | 7 | Last row index before wrapping to 0 |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0: position register, 1: pulse-length register |
| wr_data | input | 7 | Write data |
| vsync | output | 1 | Vertical sync pulse |
| vblank | output | 1 | Vertical blanking, identical to vsync |
| row | output | 7 | Current character row |
| frame_start | output | 1 | One-cycle flag when row wraps to 0 |

## Verification
The assertions assume the following about the inputs:
- vtotal stays constant and row never sits above it.
- A pulse-length write never occurs while a pulse is running.
- A host write never lands in the same cycle as a scanline boundary.

The stimulus holds vtotal at 20 throughout. It issues every write in a cycle of its own, with char_en low. It changes the pulse length only after waiting for vsync to fall. line_end is raised on a cycle with char_en low as well as on the boundary cycle, so the gating is exercised on every line.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
    // Selects which host register a write targets.
    typedef enum logic {
        SEL_POS = 1'b0,
        SEL_LEN = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/vsg_row_ctr.sv
module vsg_row_ctr #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bound,
    input  logic [ROW_W-1:0] vtotal,
    output logic [ROW_W-1:0] row_q,
    output logic [ROW_W-1:0] row_nx,
    output logic             fs_q
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             fs;
    } row_t;

    row_t st_d, st_q;
    logic at_top;

    always_comb begin
        at_top    = (st_q.row == vtotal);
        row_nx    = at_top ? '0 : ROW_W'(st_q.row + 1'b1);
        st_d      = st_q;
        st_d.fs   = bound && at_top;
        if (bound) st_d.row = row_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign row_q = st_q.row;
    assign fs_q  = st_q.fs;

    a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
        bound && (row_q != vtotal) |=> row_q == ROW_W'($past(row_q) + 1'b1));
    a_r2_row_idle: assert property (@(posedge clk) disable iff (rst)
        !bound |=> $stable(row_q));
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        bound && (row_q == vtotal) |=> (row_q == '0) && fs_q);
    a_r3_fs_row: assert property (@(posedge clk) disable iff (rst)
        fs_q |-> row_q == '0);
endmodule

// File: rtl/vsg_regs.sv
module vsg_regs
    import vsg_pkg::*;
#(
    parameter int ROW_W      = 7,
    parameter int PW_W       = 4,
    parameter int DEF_WIDTH  = 16,
    parameter bit PROG_WIDTH = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [ROW_W-1:0] wr_data,
    output logic [ROW_W-1:0] pos_q,
    output logic             pos_wr,
    output logic [PW_W:0]    width
);
    localparam int CNT_W = PW_W + 1;
    localparam logic [CNT_W-1:0] FULL   = CNT_W'(1) << PW_W;
    localparam logic [PW_W-1:0]  WF_RST = PW_W'(DEF_WIDTH);

    typedef struct packed {
        logic [ROW_W-1:0] pos;
        logic [PW_W-1:0]  wf;
    } regs_t;

    regs_t st_d, st_q;
    logic [PW_W-1:0] wf_nx;
    logic            len_wr;

    assign pos_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_POS);
    assign len_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_LEN);

    generate
        if (PROG_WIDTH) begin : g_prog
            assign wf_nx = len_wr ? wr_data[PW_W-1:0] : st_q.wf;
        end else begin : g_fixed
            assign wf_nx = WF_RST;
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.wf  = wf_nx;
        if (pos_wr) st_d.pos = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pos <= '0;
            st_q.wf  <= WF_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_q = st_q.pos;
    assign width = (st_q.wf == '0) ? FULL : {1'b0, st_q.wf};

    a_r7_pos_load: assert property (@(posedge clk) disable iff (rst)
        pos_wr |=> pos_q == $past(wr_data));
    a_r7_pos_hold: assert property (@(posedge clk) disable iff (rst)
        !pos_wr |=> $stable(pos_q));
    a_r10_width_range: assert property (@(posedge clk) disable iff (rst)
        (width != '0) && (width <= FULL));
endmodule

// File: rtl/vsg_pulse.sv
module vsg_pulse #(
    parameter int ROW_W = 7,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bound,
    input  logic [ROW_W-1:0] row_q,
    input  logic [ROW_W-1:0] row_nx,
    input  logic [ROW_W-1:0] pos,
    input  logic [CNT_W-1:0] width,
    input  logic             pos_wr,
    input  logic [ROW_W-1:0] wr_data,
    output logic             act_q
);
    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } pulse_t;

    pulse_t st_d, st_q;
    logic hit_line, hit_wr, last;

    always_comb begin
        hit_line = bound && (row_nx == pos);
        hit_wr   = pos_wr && (wr_data == row_q);
        last     = (CNT_W'(st_q.cnt + 1'b1) == width);
        st_d     = st_q;
        if (st_q.act) begin
            if (bound) begin
                if (last) begin
                    st_d.act = 1'b0;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = CNT_W'(st_q.cnt + 1'b1);
                end
            end
        end else if (hit_line || hit_wr) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign act_q = st_q.act;

    a_r4_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(act_q) |-> $past((bound && (row_nx == pos)) || (pos_wr && (wr_data == row_q))));
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        act_q && !bound |=> act_q);
    a_r5_fall_on_bound: assert property (@(posedge clk) disable iff (rst)
        $fell(act_q) |-> $past(bound));
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        act_q |-> st_q.cnt < width);
    a_r8_cnt_steady: assert property (@(posedge clk) disable iff (rst)
        act_q && !bound |=> $stable(st_q.cnt));
endmodule

// File: rtl/vsync_gen.sv
module vsync_gen #(
    parameter int ROW_W      = 7,
    parameter int PW_W       = 4,
    parameter int DEF_WIDTH  = 16,
    parameter bit PROG_WIDTH = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             char_en,
    input  logic             line_end,
    input  logic [ROW_W-1:0] vtotal,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [ROW_W-1:0] wr_data,
    output logic             vsync,
    output logic             vblank,
    output logic [ROW_W-1:0] row,
    output logic             frame_start
);
    localparam int CNT_W = PW_W + 1;

    logic             bound;
    logic [ROW_W-1:0] row_q, row_nx, pos_q;
    logic             pos_wr;
    logic [CNT_W-1:0] width;
    logic             act_q;

    assign bound = char_en && line_end;

    vsg_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst(rst), .bound(bound), .vtotal(vtotal),
        .row_q(row_q), .row_nx(row_nx), .fs_q(frame_start)
    );

    vsg_regs #(.ROW_W(ROW_W), .PW_W(PW_W), .DEF_WIDTH(DEF_WIDTH),
               .PROG_WIDTH(PROG_WIDTH)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pos_q(pos_q), .pos_wr(pos_wr), .width(width)
    );

    vsg_pulse #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_pulse (
        .clk(clk), .rst(rst), .bound(bound), .row_q(row_q), .row_nx(row_nx),
        .pos(pos_q), .width(width), .pos_wr(pos_wr), .wr_data(wr_data),
        .act_q(act_q)
    );

    assign vsync  = act_q;
    assign vblank = act_q;
    assign row    = row_q;

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !vsync && !frame_start && (row == '0));
endmodule

// File: tb/sim_vsync_gen.sv
module sim_vsync_gen;
    localparam int VT = 20;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst, char_en, line_end, wr_en, wr_sel;
    logic [6:0] vtotal, wr_data, row;
    logic       vsync, vblank, frame_start;

    vsync_gen u0 (
        .clk(clk), .rst(rst), .char_en(char_en), .line_end(line_end),
        .vtotal(vtotal), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .vsync(vsync), .vblank(vblank), .row(row), .frame_start(frame_start)
    );

    int total = 0, bad = 0;
    int erow = 0;
    logic efs = 1'b0, pv = 1'b0, done = 1'b0;
    int hl = 0, last_len = 0, rise_row = -1, rises = 0, falls = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic ce, input logic le, input logic we,
                       input logic sel, input logic [6:0] d);
        int prow;
        bit strobe;
        char_en = ce; line_end = le; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        prow   = erow;
        strobe = ce && le;
        if (strobe) begin
            efs  = (erow == VT);
            erow = efs ? 0 : erow + 1;
        end else begin
            efs = 1'b0;
        end
        chk(int'(row) == erow, "R2 row", int'(row), erow);
        chk(frame_start == efs, "R3 frame_start", int'(frame_start), int'(efs));
        chk(vblank == vsync, "R9 vblank", int'(vblank), int'(vsync));
        if (pv && strobe) hl++;
        if (vsync && !pv) begin
            rises++;
            rise_row = int'(row);
            hl = 0;
            chk(strobe || (we && !sel && int'(d) == prow), "R4 rise cause", 0, 1);
        end
        if (!vsync && pv) begin
            falls++;
            last_len = hl;
            chk(strobe, "R5 fall at boundary", 0, 1);
        end
        pv = vsync;
    endtask

    task automatic line();
        for (int i = 0; i < 8; i++) cyc(i % 2 == 1, i >= 6, 1'b0, 1'b0, 7'd0);
    endtask

    task automatic wr(input logic sel, input logic [6:0] d);
        cyc(1'b0, 1'b0, 1'b1, sel, d);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100 && vsync; k++) line();
    endtask

    task automatic wait_rise();
        int r0 = rises;
        for (int k = 0; k < 100 && rises == r0; k++) line();
        chk(rises > r0, "R4 pulse seen", rises, r0 + 1);
    endtask

    task automatic wait_fall();
        int f0 = falls;
        for (int k = 0; k < 100 && falls == f0; k++) line();
        chk(falls > f0, "R5 pulse ended", falls, f0 + 1);
    endtask

    initial begin
        rst = 1'b1; char_en = 0; line_end = 0; wr_en = 0; wr_sel = 0;
        wr_data = 0; vtotal = 7'(VT);
        repeat (3) @(negedge clk);
        chk(!vsync && !vblank && !frame_start && row == 0, "R1 in reset", int'(vsync), 0);
        rst = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 7'd0);
        chk(!vsync && !vblank && !frame_start && row == 0, "R1 after reset", int'(row), 0);

        // R1 default position 0 and default length 16
        wait_rise();
        chk(rise_row == 0, "R1 reset position", rise_row, 0);
        wait_fall();
        chk(last_len == 16, "R1 reset length", last_len, 16);

        // R4 / R7 sweep of every position
        for (int p = 0; p <= VT; p++) begin
            wait_idle();
            if (erow == p) line();
            wr(1'b0, 7'(p));
            chk(!vsync, "R7 no start on other row", int'(vsync), 0);
            wait_rise();
            chk(rise_row == p, "R7 position sweep", rise_row, p);
        end

        // R5 / R10 sweep of every length
        for (int w = 1; w <= 16; w++) begin
            wait_idle();
            wr(1'b1, 7'(w % 16));
            wait_rise();
            wait_fall();
            chk(last_len == w, "R10 length sweep", last_len, w);
        end
        wait_idle();
        wr(1'b1, 7'd0);

        // R6 write of the current row mid-line
        wait_idle();
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 7'd0);
        wr(1'b0, 7'(erow));
        chk(vsync == 1'b1, "R6 immediate start", int'(vsync), 1);
        chk(rise_row == erow, "R6 start row", rise_row, erow);
        wait_fall();
        chk(last_len == 16, "R6 length", last_len, 16);

        // R7 non-matching write does not start; stored value used next
        begin
            int v;
            wait_idle();
            v = (erow + 3) % (VT + 1);
            wr(1'b0, 7'(v));
            for (int i = 0; i < 3; i++) begin
                cyc(1'b1, 1'b0, 1'b0, 1'b0, 7'd0);
                chk(!vsync, "R7 no start mid-line", int'(vsync), 0);
            end
            wait_rise();
            chk(rise_row == v, "R7 new position", rise_row, v);
        end

        // R8 writes during a pulse
        begin
            int v2;
            line();
            line();
            chk(vsync == 1'b1, "R8 pulse running", int'(vsync), 1);
            wr(1'b0, 7'(erow));
            v2 = (erow + 10) % (VT + 1);
            line();
            wr(1'b0, 7'(v2));
            wait_fall();
            chk(last_len == 16, "R8 length kept", last_len, 16);
            wait_rise();
            chk(rise_row == v2, "R8 later position", rise_row, v2);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule